// File: doc/BRIEF.md
# Parallel LCD Bus Cycle Timer

This block turns single-word host requests into bus cycles on an 8080-style parallel display port. A request is a command write, a data write or a read. For each accepted request the block runs a tick counter from zero and places the chip-select, write-strobe and read-strobe edges at programmed tick positions. It also drives the address/command line and the data bus with its output enable, and it captures the read data at a programmed access tick.

A tick is one clock, or two clocks when the doubler input is set. All timing fields are static configuration inputs. Software is expected to keep them self-consistent: each strobe's deassert tick is above its assert tick, each cycle length is at least its strobe's deassert tick, and the access tick is above the read-strobe assert tick. After a write, an optional gap of inactive chip-select ticks runs before the next request can be taken.

Top module: `lcd_bus_timer`

## Requirements
- R1: After reset, busy, lcd_oe and rsp_valid are low, and CS, WE and RE sit at their inactive levels.
- R2: In both write and read cycles, CS is active exactly in the ticks t with cfg_cs_on <= t < cfg_cs_off and t below the cycle length, where tick 0 starts on the clock after the accepting edge.
- R3: WE is active only in write cycles, in ticks cfg_we_on <= t < cfg_we_off. RE is active only in read cycles, in ticks cfg_re_on <= t < cfg_re_off. The two are never active together.
- R4: req_kind 2'b00 is a command write and 2'b01 is a data write; 2'b10 and 2'b11 are reads. During a cycle the logical A0 is 0 for a command write and 1 otherwise.
- R5: A polarity bit of 0 makes CS, WE or RE active-low; a bit of 1 makes it active-high. cfg_a0_pol set inverts the A0 level.
- R6: busy (and a low req_ready) lasts from the clock after the accepting edge for cfg_wr_cyc ticks on a write or cfg_rd_cyc ticks on a read. Requests presented while busy are ignored.
- R7: After a write, busy stays high for a further cfg_cs_gap ticks, during which CS is inactive. A gap of 0 adds nothing.
- R8: In a read, lcd_din is captured on the first clock of tick cfg_acc. rsp_valid then pulses for one clock, on the clock that follows, with the captured word on rsp_rdata.
- R9: With cfg_tick_x2 set, every tick lasts two clocks, and all positions and lengths scale accordingly.
- R10: lcd_oe is high in write cycles from tick 0 until tick cfg_we_off, and low otherwise. lcd_dout holds the request word for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cs_on | input | 4 | CS assert tick |
| cfg_cs_off | input | 6 | CS deassert tick |
| cfg_we_on | input | 4 | WE assert tick |
| cfg_we_off | input | 6 | WE deassert tick |
| cfg_re_on | input | 4 | RE assert tick |
| cfg_re_off | input | 6 | RE deassert tick |
| cfg_wr_cyc | input | 6 | Write cycle length in ticks |
| cfg_rd_cyc | input | 6 | Read cycle length in ticks |
| cfg_cs_gap | input | 6 | CS idle ticks after a write |
| cfg_acc | input | 6 | Read capture tick |
| cfg_tick_x2 | input | 1 | Two clocks per tick |
| cfg_cs_pol | input | 1 | CS polarity, 1 = active-high |
| cfg_we_pol | input | 1 | WE polarity, 1 = active-high |
| cfg_re_pol | input | 1 | RE polarity, 1 = active-high |
| cfg_a0_pol | input | 1 | A0 inversion |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Request type |
| req_wdata | input | 16 | Word to write |
| req_ready | output | 1 | Request can be taken |
| busy | output | 1 | Access or gap in progress |
| rsp_valid | output | 1 | Read word valid pulse |
| rsp_rdata | output | 16 | Captured read word |
| lcd_cs | output | 1 | Chip select |
| lcd_we | output | 1 | Write strobe |
| lcd_re | output | 1 | Read strobe |
| lcd_a0 | output | 1 | Command/data select |
| lcd_dout | output | 16 | Bus data out |
| lcd_oe | output | 1 | Bus output enable |
| lcd_din | input | 16 | Bus data in |

## Verification
The hardest case to reach is the exact capture clock, because a stable lcd_din cannot show whether the sample was taken a tick early or late. The bench therefore drives a marker word on lcd_din only during the single clock where the capture is due, and a filler word at all other times, in both one-clock and two-clock tick modes. A request presented in the middle of a busy write probes the hold-off rule: the bench checks that no read strobe and no response appear across the whole window.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_GAP  = 2'd2
   } seq_state_t;

   localparam logic [1:0] KIND_CMD  = 2'b00;
   localparam logic [1:0] KIND_DATA = 2'b01;

   function automatic logic kind_is_write(input logic [1:0] kind);
      return ~kind[1];
   endfunction

   function automatic logic kind_a0(input logic [1:0] kind);
      return kind != KIND_CMD;
   endfunction
endpackage

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen #(
   parameter bit HAS_X2 = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   input  logic x2,
   output logic tick_end,
   output logic tick_first
);
   generate
      if (HAS_X2) begin : g_dbl
         logic phase;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          phase <= 1'b0;
            else if (start)      phase <= 1'b0;
            else if (run && x2)  phase <= ~phase;
         end
         assign tick_end   = ~x2 | phase;
         assign tick_first = ~x2 | ~phase;
      end else begin : g_single
         logic unused_tick_in;
         assign unused_tick_in = ^{clk, rst_n, start, run, x2};
         assign tick_end   = 1'b1;
         assign tick_first = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/lcd_cycle_seq.sv
module lcd_cycle_seq
   import lcd_bus_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_write,
   input  logic             tick_end,
   input  logic [CNT_W-1:0] cyc_len,
   input  logic [CNT_W-1:0] gap_len,
   output logic             busy,
   output logic             in_cycle,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   seq_state_t state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: if (start) begin
               state <= SEQ_RUN;
               cnt   <= '0;
            end
            SEQ_RUN: if (tick_end) begin
               if (cnt == cyc_len - ONE) begin
                  cnt   <= '0;
                  state <= (is_write && gap_len != '0) ? SEQ_GAP : SEQ_IDLE;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            SEQ_GAP: if (tick_end) begin
               if (cnt == gap_len - ONE) begin
                  cnt   <= '0;
                  state <= SEQ_IDLE;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign busy     = state != SEQ_IDLE;
   assign in_cycle = state == SEQ_RUN;
endmodule

// File: rtl/lcd_edge_window.sv
module lcd_edge_window #(
   parameter int ON_W  = 4,
   parameter int OFF_W = 6,
   parameter int CNT_W = 6
) (
   input  logic             en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [ON_W-1:0]  t_on,
   input  logic [OFF_W-1:0] t_off,
   output logic             active
);
   assign active = en && (cnt >= CNT_W'(t_on)) && (cnt < CNT_W'(t_off));
endmodule

// File: rtl/lcd_bus_timer.sv
module lcd_bus_timer
   import lcd_bus_pkg::*;
#(
   parameter int DW     = 16,
   parameter int ON_W   = 4,
   parameter int OFF_W  = 6,
   parameter int CNT_W  = 6,
   parameter bit HAS_X2 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ON_W-1:0]  cfg_cs_on,
   input  logic [OFF_W-1:0] cfg_cs_off,
   input  logic [ON_W-1:0]  cfg_we_on,
   input  logic [OFF_W-1:0] cfg_we_off,
   input  logic [ON_W-1:0]  cfg_re_on,
   input  logic [OFF_W-1:0] cfg_re_off,
   input  logic [CNT_W-1:0] cfg_wr_cyc,
   input  logic [CNT_W-1:0] cfg_rd_cyc,
   input  logic [CNT_W-1:0] cfg_cs_gap,
   input  logic [CNT_W-1:0] cfg_acc,
   input  logic             cfg_tick_x2,
   input  logic             cfg_cs_pol,
   input  logic             cfg_we_pol,
   input  logic             cfg_re_pol,
   input  logic             cfg_a0_pol,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic [DW-1:0]    req_wdata,
   output logic             req_ready,
   output logic             busy,
   output logic             rsp_valid,
   output logic [DW-1:0]    rsp_rdata,
   output logic             lcd_cs,
   output logic             lcd_we,
   output logic             lcd_re,
   output logic             lcd_a0,
   output logic [DW-1:0]    lcd_dout,
   output logic             lcd_oe,
   input  logic [DW-1:0]    lcd_din
);
   localparam int NSTB = 3;
   localparam int I_CS = 0;
   localparam int I_WE = 1;
   localparam int I_RE = 2;

   generate
      if (OFF_W < ON_W || CNT_W < OFF_W || DW < 1) begin : g_bad_cfg
         $error("lcd_bus_timer: widths must satisfy ON_W <= OFF_W <= CNT_W");
      end
   endgenerate

   logic             start, in_cycle, tick_end, tick_first;
   logic [CNT_W-1:0] cnt;
   logic             cur_wr, cur_a0;
   logic [DW-1:0]    dout_q;
   logic [CNT_W-1:0] cyc_len;

   assign start     = req_valid && !busy;
   assign req_ready = !busy;
   assign cyc_len   = cur_wr ? cfg_wr_cyc : cfg_rd_cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_wr <= 1'b0;
         cur_a0 <= 1'b0;
         dout_q <= '0;
      end else if (start) begin
         cur_wr <= kind_is_write(req_kind);
         cur_a0 <= kind_a0(req_kind);
         dout_q <= req_wdata;
      end
   end

   lcd_tick_gen #(.HAS_X2(HAS_X2)) u_tick (
      .clk(clk), .rst_n(rst_n), .start(start), .run(busy),
      .x2(cfg_tick_x2), .tick_end(tick_end), .tick_first(tick_first)
   );

   lcd_cycle_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .is_write(cur_wr),
      .tick_end(tick_end), .cyc_len(cyc_len), .gap_len(cfg_cs_gap),
      .busy(busy), .in_cycle(in_cycle), .cnt(cnt)
   );

   logic [ON_W-1:0]  on_a  [NSTB];
   logic [OFF_W-1:0] off_a [NSTB];
   logic [NSTB-1:0]  en_a, act_a, pol_a;

   assign on_a[I_CS]  = cfg_cs_on;  assign off_a[I_CS] = cfg_cs_off;
   assign on_a[I_WE]  = cfg_we_on;  assign off_a[I_WE] = cfg_we_off;
   assign on_a[I_RE]  = cfg_re_on;  assign off_a[I_RE] = cfg_re_off;
   assign en_a[I_CS]  = in_cycle;
   assign en_a[I_WE]  = in_cycle && cur_wr;
   assign en_a[I_RE]  = in_cycle && !cur_wr;
   assign pol_a       = {cfg_re_pol, cfg_we_pol, cfg_cs_pol};

   logic [NSTB-1:0] lvl_a;
   generate
      for (genvar s = 0; s < NSTB; s++) begin : g_stb
         lcd_edge_window #(.ON_W(ON_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_win (
            .en(en_a[s]), .cnt(cnt), .t_on(on_a[s]), .t_off(off_a[s]),
            .active(act_a[s])
         );
         assign lvl_a[s] = pol_a[s] ? act_a[s] : ~act_a[s];
      end
   endgenerate

   assign lcd_cs   = lvl_a[I_CS];
   assign lcd_we   = lvl_a[I_WE];
   assign lcd_re   = lvl_a[I_RE];
   assign lcd_a0   = cur_a0 ^ cfg_a0_pol;
   assign lcd_dout = dout_q;
   assign lcd_oe   = in_cycle && cur_wr && (cnt < CNT_W'(cfg_we_off));

   logic capture;
   assign capture = in_cycle && !cur_wr && tick_first && (cnt == cfg_acc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= lcd_din;
      end
   end
endmodule

// File: rtl/lcd_bus_timer_chk.sv
module lcd_bus_timer_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          lcd_we,
   input logic          lcd_re,
   input logic          lcd_oe,
   input logic [DW-1:0] lcd_dout,
   input logic          rsp_valid,
   input logic          cfg_we_pol,
   input logic          cfg_re_pol
);
   AST_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> lcd_we == ~cfg_we_pol); // R3
   AST_RE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> lcd_re == ~cfg_re_pol); // R3
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !((lcd_we == cfg_we_pol) && (lcd_re == cfg_re_pol))); // R3
   AST_OE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_oe |-> (lcd_re != cfg_re_pol) && busy); // R10
   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(lcd_dout)); // R10
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R8
endmodule

bind lcd_bus_timer lcd_bus_timer_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_lcd_bus_timer.sv
module tb_lcd_bus_timer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [3:0] cfg_cs_on, cfg_we_on, cfg_re_on;
   logic [5:0] cfg_cs_off, cfg_we_off, cfg_re_off;
   logic [5:0] cfg_wr_cyc, cfg_rd_cyc, cfg_cs_gap, cfg_acc;
   logic cfg_tick_x2, cfg_cs_pol, cfg_we_pol, cfg_re_pol, cfg_a0_pol;
   logic req_valid;
   logic [1:0] req_kind;
   logic [15:0] req_wdata, lcd_din;
   logic req_ready, busy, rsp_valid, lcd_cs, lcd_we, lcd_re, lcd_a0, lcd_oe;
   logic [15:0] rsp_rdata, lcd_dout;

   lcd_bus_timer dut (.*);

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string lbl, input string req,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", lbl, req, act, exp);
      end
   endtask

   task automatic set_cfg(input int cson, input int csoff, input int weon,
                          input int weoff, input int reon, input int reoff,
                          input int wcyc, input int rcyc, input int gap,
                          input int acc, input bit x2, input bit pol);
      @(negedge clk);
      cfg_cs_on = 4'(cson); cfg_cs_off = 6'(csoff);
      cfg_we_on = 4'(weon); cfg_we_off = 6'(weoff);
      cfg_re_on = 4'(reon); cfg_re_off = 6'(reoff);
      cfg_wr_cyc = 6'(wcyc); cfg_rd_cyc = 6'(rcyc);
      cfg_cs_gap = 6'(gap);  cfg_acc = 6'(acc);
      cfg_tick_x2 = x2;
      cfg_cs_pol = pol; cfg_we_pol = pol; cfg_re_pol = pol; cfg_a0_pol = pol;
   endtask

   // Issue one request and compare every clock of the access.
   task automatic run_acc(input string lbl, input logic [1:0] kind,
                          input logic [15:0] word, input bit poke);
      int m, cyc, total, t, nrsp;
      bit wr;
      int e_cs = 0, e_we = 0, e_re = 0, e_a0 = 0, e_oe = 0, e_bz = 0, e_rsp = 0, e_do = 0;
      logic [15:0] mark;
      m = cfg_tick_x2 ? 2 : 1;
      wr = (kind[1] == 1'b0);
      cyc = wr ? int'(cfg_wr_cyc) : int'(cfg_rd_cyc);
      total = (cyc + (wr ? int'(cfg_cs_gap) : 0)) * m;
      mark = word ^ 16'h5A3C;
      nrsp = 0;
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_wdata = word; lcd_din = 16'hAAAA;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < total + 2; k++) begin
         bit inc, x_cs, x_we, x_re;
         t = k / m;
         inc = k < cyc * m;
         x_cs = inc && t >= int'(cfg_cs_on) && t < int'(cfg_cs_off);
         x_we = inc && wr && t >= int'(cfg_we_on) && t < int'(cfg_we_off);
         x_re = inc && !wr && t >= int'(cfg_re_on) && t < int'(cfg_re_off);
         if ((lcd_cs == cfg_cs_pol) != x_cs) e_cs++;
         if ((lcd_we == cfg_we_pol) != x_we) e_we++;
         if ((lcd_re == cfg_re_pol) != x_re) e_re++;
         if (inc && lcd_a0 != ((kind != 2'b00) ^ cfg_a0_pol)) e_a0++;
         if (lcd_oe != (inc && wr && t < int'(cfg_we_off))) e_oe++;
         if (busy != (k < total) || req_ready == busy) e_bz++;
         if (inc && wr && lcd_dout != word) e_do++;
         if (rsp_valid) nrsp++;
         if (rsp_valid != (!wr && k == int'(cfg_acc) * m + 1)) e_rsp++;
         lcd_din = (k == int'(cfg_acc) * m) ? mark : 16'hAAAA;
         if (poke && k == 1) begin req_valid = 1'b1; req_kind = 2'b10; end
         if (poke && k == 2) req_valid = 1'b0;
         @(negedge clk);
      end
      chk(e_cs == 0, lbl, "R2 CS window", e_cs, 0);
      chk(e_we == 0 && e_re == 0, lbl, "R3 WE/RE windows", e_we + e_re, 0);
      chk(e_a0 == 0, lbl, "R4 A0 level", e_a0, 0);
      chk(e_bz == 0, lbl, wr ? "R7 busy incl gap" : "R6 busy length", e_bz, 0);
      if (wr) chk(e_oe == 0 && e_do == 0, lbl, "R10 OE and data", e_oe + e_do, 0);
      chk(e_rsp == 0 && nrsp == (wr ? 0 : 1), lbl, "R8 rsp pulse", nrsp, wr ? 0 : 1);
      if (!wr) chk(rsp_rdata == mark, lbl, "R8 captured word", rsp_rdata, mark);
   endtask

   task automatic test_reset();
      chk(busy == 0 && lcd_oe == 0 && rsp_valid == 0, "reset", "R1 idle outputs",
          {busy, lcd_oe, rsp_valid}, 0);
      chk(lcd_cs && lcd_we && lcd_re, "reset", "R1 strobes inactive",
          {lcd_cs, lcd_we, lcd_re}, 7);
   endtask

   task automatic test_cmd_write();
      set_cfg(1, 8, 2, 5, 1, 4, 9, 10, 3, 6, 0, 0);
      run_acc("cmd_write", 2'b00, 16'h1234, 0);
   endtask

   task automatic test_data_write();
      set_cfg(0, 6, 1, 6, 1, 4, 6, 8, 2, 5, 0, 0);
      run_acc("data_write", 2'b01, 16'hBEEF, 0);
   endtask

   task automatic test_read();
      set_cfg(0, 9, 2, 5, 2, 7, 6, 9, 3, 4, 0, 0);
      run_acc("read", 2'b10, 16'h0F0F, 0);
   endtask

   task automatic test_x2();
      set_cfg(1, 6, 1, 4, 1, 5, 6, 7, 2, 3, 1, 0);
      run_acc("R9 x2 write", 2'b01, 16'hC0DE, 0);
      run_acc("R9 x2 read", 2'b10, 16'h7711, 0);
   endtask

   task automatic test_pol();
      set_cfg(1, 7, 2, 6, 1, 4, 7, 6, 2, 3, 0, 1);
      run_acc("R5 pol write", 2'b00, 16'h00FF, 0);
      run_acc("R5 pol read", 2'b11, 16'h1357, 0);
   endtask

   task automatic test_holdoff();
      set_cfg(0, 8, 1, 6, 1, 4, 8, 6, 4, 3, 0, 0);
      run_acc("R6 holdoff", 2'b01, 16'hA5A5, 1);
   endtask

   task automatic test_nogap_edges();
      set_cfg(0, 5, 0, 5, 0, 6, 5, 6, 0, 5, 0, 0);
      run_acc("R7 nogap", 2'b00, 16'h4242, 0);
      run_acc("R8 late acc", 2'b11, 16'h9999, 0);
   endtask

   initial begin
      set_cfg(0, 1, 0, 1, 0, 1, 1, 1, 0, 1, 0, 0);
      req_valid = 1'b0; req_kind = 2'b00; req_wdata = '0; lcd_din = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_cmd_write();
      test_data_write();
      test_read();
      test_x2();
      test_pol();
      test_holdoff();
      test_nogap_edges();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule